// File: doc/BRIEF.md
# USB Pipe Ready / Not-Ready / Empty Status Interrupt Generator

This block sits beside the packet engine of a full-speed USB device controller. Each transaction on a pipe is reported as a one-cycle event. The event carries the pipe index, the token type and qualifiers: data moved, handshake, NAK, short packet, CRC error, overrun, oversize packet and transmit buffer drained. From these events and the configuration of each pipe, the block keeps three per-pipe status vectors. The ready vector means the buffer can be accessed by the CPU. The not-ready vector means the device had to refuse a token, or an isochronous packet was damaged. The empty vector means transmit data has run out or an oversize packet was stalled. The block also holds two global isochronous error flags.

Each pipe has a two-bit response field, an isochronous flag, an end-of-transfer option and a transaction counter. With the end-of-transfer option on, the ready indication for received data waits until the whole transfer has finished. A simple write port takes the place of the CPU bus. Software uses it to clear status bits and to load the per-pipe interrupt enables. The interrupt request merges every enabled status bit.

Top module: `pipe_ready_irq`

## Requirements
- R1: After reset, all status vectors, all enables and both error flags are 0, and irq is 0.
- R2: An event with ev_nak on a non-isochronous pipe sets that pipe's not-ready bit. This holds for ev_token 2'b00 (IN), 2'b01 (OUT) and 2'b10 (PING). The bit is set only when the pipe's response field equals 2'b01. Any other response value leaves all status unchanged.
- R3: A CRC error (ev_crc) or overrun (ev_ovrn) on an isochronous pipe sets err_flags bit 0 or bit 1 respectively. It also sets the pipe's not-ready bit when the response field is 2'b01. On a non-isochronous pipe, these inputs change no output.
- R4: With the end-of-transfer option off, a good OUT data packet sets the pipe's ready bit only when cpu_unread for that pipe is 0. A good packet has ev_data and an ACK (or an isochronous pipe), and carries no NAK, CRC, overrun or oversize marking. A zero-length packet counts as a good packet.
- R5: With the end-of-transfer option on, a good OUT packet sets the ready bit only when the transfer ends. A transfer ends on a short packet, or when the packet count since the last end reaches a nonzero transaction counter. The count then restarts.
- R6: An IN data packet that is acknowledged sets the pipe's ready bit. When ev_tx_empty is also high, it sets the empty bit as well. Without the ACK, on a non-isochronous pipe, neither bit is set.
- R7: An OUT event with ev_mps_over on a non-isochronous pipe sets the empty bit and not the ready bit.
- R8: On an isochronous pipe, a data event sets the ready and empty bits exactly as if ev_ack were high.
- R9: A write with wr_sel 0, 1, 2 or 6 clears the bits of the ready, not-ready, empty or error vector where wr_data is 0, and keeps the bits where wr_data is 1. A set in the same cycle wins over the clear.
- R10: wr_sel 3, 4 and 5 load the ready, not-ready and empty enable vectors from wr_data.
- R11: irq is 1 exactly when some status bit and its matching enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | Transaction event strobe |
| ev_pipe | input | $clog2(NP) | Pipe index of the event |
| ev_token | input | 2 | 00 IN, 01 OUT, 10 PING |
| ev_data | input | 1 | A data packet was moved |
| ev_ack | input | 1 | ACK handshake took place |
| ev_nak | input | 1 | Device answered NAK |
| ev_short | input | 1 | Short or zero-length packet |
| ev_crc | input | 1 | CRC error detected |
| ev_ovrn | input | 1 | Receive overrun |
| ev_mps_over | input | 1 | OUT packet longer than max packet size, stalled |
| ev_tx_empty | input | 1 | No transmit data left after this packet |
| cpu_unread | input | NP | CPU side still holds unread data, per pipe |
| cfg_resp | input | 2*NP | Response field per pipe |
| cfg_iso | input | NP | Pipe is isochronous |
| cfg_eot | input | NP | Ready only at end of transfer |
| cfg_trncnt | input | CW*NP | Transaction counter per pipe, 0 = unused |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target register code |
| wr_data | input | NP | Write data |
| rdy_sts | output | NP | Ready status |
| nrdy_sts | output | NP | Not-ready status |
| emp_sts | output | NP | Empty status |
| err_flags | output | 2 | bit0 CRC error, bit1 overrun |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the response-field gate with a NAK sent under the wrong mode. A design without the gate would raise not-ready there. It sends a CRC error on a bulk pipe, which a careless design would flag. It runs a three-packet end-of-transfer sequence and a short packet that ends a transfer early. A design with an off-by-one in the count would raise ready one packet early or late. It also clears a bit in the same cycle as a set on that bit, which a design that gives clear the priority would lose. It tests an isochronous packet with no ACK and a received packet while the CPU still holds data. A design that got these wrong would either drop or invent ready bits.

// File: rtl/usbpst_pkg.sv
package usbpst_pkg;
  typedef enum logic [1:0] {
    TOK_IN   = 2'b00,
    TOK_OUT  = 2'b01,
    TOK_PING = 2'b10,
    TOK_RSV  = 2'b11
  } tok_e;

  typedef enum logic [2:0] {
    SEL_RDY   = 3'd0,
    SEL_NRDY  = 3'd1,
    SEL_EMP   = 3'd2,
    SEL_RDYEN = 3'd3,
    SEL_NRDYEN= 3'd4,
    SEL_EMPEN = 3'd5,
    SEL_ERR   = 3'd6,
    SEL_NONE  = 3'd7
  } sel_e;

  localparam logic [1:0] RESP_BUF = 2'b01;

  // transfer end: short packet, or this packet brings the count to the limit
  function automatic logic xfer_done(input logic [15:0] cnt,
                                     input logic [15:0] lim,
                                     input logic shrt);
    logic [16:0] nxt;
    nxt = {1'b0, cnt} + 17'd1;
    return shrt || ((lim != 16'd0) && (nxt >= {1'b0, lim}));
  endfunction
endpackage

// File: rtl/usbpst_flag_bank.sv
module usbpst_flag_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] keep_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] held;
  assign held = clr_we ? (q & keep_mask) : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= held | set_i;
  end
endmodule

// File: rtl/usbpst_xfer_cnt.sv
module usbpst_xfer_cnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          fin,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= fin ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/usbpst_evt_decode.sv
module usbpst_evt_decode
  import usbpst_pkg::*;
#(
  parameter int NP = 4,
  parameter int CW = 6,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic            ev_valid,
  input  logic [PW-1:0]   ev_pipe,
  input  logic [1:0]      ev_token,
  input  logic            ev_data,
  input  logic            ev_ack,
  input  logic            ev_nak,
  input  logic            ev_short,
  input  logic            ev_crc,
  input  logic            ev_ovrn,
  input  logic            ev_mps_over,
  input  logic            ev_tx_empty,
  input  logic [NP-1:0]   cpu_unread,
  input  logic [2*NP-1:0] cfg_resp,
  input  logic [NP-1:0]   cfg_iso,
  input  logic [NP-1:0]   cfg_eot,
  input  logic [CW*NP-1:0] cfg_trncnt,
  input  logic [CW*NP-1:0] cnt_flat,
  output logic [NP-1:0]   rdy_set,
  output logic [NP-1:0]   nrdy_set,
  output logic [NP-1:0]   emp_set,
  output logic [1:0]      err_set,
  output logic [NP-1:0]   cnt_adv,
  output logic [NP-1:0]   cnt_fin
);
  logic          iso, bufm, hs, nak_hit, err_hit, rx_good, tx_good, stall, fin;
  logic [CW-1:0] cur_cnt, cur_lim;

  always_comb begin
    iso     = cfg_iso[ev_pipe];
    bufm    = (cfg_resp[2*ev_pipe +: 2] == RESP_BUF);
    hs      = iso | ev_ack;
    cur_cnt = cnt_flat[CW*ev_pipe +: CW];
    cur_lim = cfg_trncnt[CW*ev_pipe +: CW];
    fin     = xfer_done(16'(cur_cnt), 16'(cur_lim), ev_short);
    nak_hit = ev_valid & ev_nak & ~iso;
    err_hit = ev_valid & iso & (ev_crc | ev_ovrn);
    rx_good = ev_valid & (ev_token == TOK_OUT) & ev_data & hs & ~ev_nak
              & ~ev_crc & ~ev_ovrn & ~ev_mps_over;
    tx_good = ev_valid & (ev_token == TOK_IN) & ev_data & hs & ~ev_nak;
    stall   = ev_valid & (ev_token == TOK_OUT) & ev_mps_over & ~iso;
  end

  for (genvar i = 0; i < NP; i++) begin : g_pipe
    logic hit;
    assign hit         = (ev_pipe == PW'(i));
    assign nrdy_set[i] = hit & bufm & (nak_hit | err_hit);
    assign rdy_set[i]  = hit & (tx_good |
                         (rx_good & (cfg_eot[i] ? fin : ~cpu_unread[i])));
    assign emp_set[i]  = hit & ((tx_good & ev_tx_empty) | stall);
    assign cnt_adv[i]  = hit & rx_good & cfg_eot[i];
    assign cnt_fin[i]  = hit & fin;
  end

  assign err_set = {ev_valid & iso & ev_ovrn, ev_valid & iso & ev_crc};
endmodule

// File: rtl/usbpst_irq_merge.sv
module usbpst_irq_merge #(
  parameter int NP = 4
) (
  input  logic [NP-1:0] rdy_sts,
  input  logic [NP-1:0] nrdy_sts,
  input  logic [NP-1:0] emp_sts,
  input  logic [NP-1:0] rdy_en,
  input  logic [NP-1:0] nrdy_en,
  input  logic [NP-1:0] emp_en,
  output logic          irq
);
  assign irq = |{rdy_sts & rdy_en, nrdy_sts & nrdy_en, emp_sts & emp_en};
endmodule

// File: rtl/pipe_ready_irq.sv
module pipe_ready_irq
  import usbpst_pkg::*;
#(
  parameter int NP = 4,
  parameter int CW = 6,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [PW-1:0]    ev_pipe,
  input  logic [1:0]       ev_token,
  input  logic             ev_data,
  input  logic             ev_ack,
  input  logic             ev_nak,
  input  logic             ev_short,
  input  logic             ev_crc,
  input  logic             ev_ovrn,
  input  logic             ev_mps_over,
  input  logic             ev_tx_empty,
  input  logic [NP-1:0]    cpu_unread,
  input  logic [2*NP-1:0]  cfg_resp,
  input  logic [NP-1:0]    cfg_iso,
  input  logic [NP-1:0]    cfg_eot,
  input  logic [CW*NP-1:0] cfg_trncnt,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [NP-1:0]    wr_data,
  output logic [NP-1:0]    rdy_sts,
  output logic [NP-1:0]    nrdy_sts,
  output logic [NP-1:0]    emp_sts,
  output logic [1:0]       err_flags,
  output logic             irq
);
  logic [NP-1:0]    rdy_set, nrdy_set, emp_set, cnt_adv, cnt_fin;
  logic [1:0]       err_set;
  logic [CW*NP-1:0] cnt_flat;
  logic [NP-1:0]    rdy_en, nrdy_en, emp_en;

  usbpst_evt_decode #(.NP(NP), .CW(CW)) u_dec (
    .ev_valid(ev_valid), .ev_pipe(ev_pipe), .ev_token(ev_token),
    .ev_data(ev_data), .ev_ack(ev_ack), .ev_nak(ev_nak),
    .ev_short(ev_short), .ev_crc(ev_crc), .ev_ovrn(ev_ovrn),
    .ev_mps_over(ev_mps_over), .ev_tx_empty(ev_tx_empty),
    .cpu_unread(cpu_unread), .cfg_resp(cfg_resp), .cfg_iso(cfg_iso),
    .cfg_eot(cfg_eot), .cfg_trncnt(cfg_trncnt), .cnt_flat(cnt_flat),
    .rdy_set(rdy_set), .nrdy_set(nrdy_set), .emp_set(emp_set),
    .err_set(err_set), .cnt_adv(cnt_adv), .cnt_fin(cnt_fin)
  );

  for (genvar i = 0; i < NP; i++) begin : g_cnt
    usbpst_xfer_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(cnt_adv[i]), .fin(cnt_fin[i]),
      .cnt(cnt_flat[CW*i +: CW])
    );
  end

  logic wr_rdy, wr_nrdy, wr_emp, wr_err;
  assign wr_rdy  = wr_en && (wr_sel == SEL_RDY);
  assign wr_nrdy = wr_en && (wr_sel == SEL_NRDY);
  assign wr_emp  = wr_en && (wr_sel == SEL_EMP);
  assign wr_err  = wr_en && (wr_sel == SEL_ERR);

  usbpst_flag_bank #(.W(NP)) u_rdy (
    .clk(clk), .rst_n(rst_n), .set_i(rdy_set), .clr_we(wr_rdy),
    .keep_mask(wr_data), .q(rdy_sts));
  usbpst_flag_bank #(.W(NP)) u_nrdy (
    .clk(clk), .rst_n(rst_n), .set_i(nrdy_set), .clr_we(wr_nrdy),
    .keep_mask(wr_data), .q(nrdy_sts));
  usbpst_flag_bank #(.W(NP)) u_emp (
    .clk(clk), .rst_n(rst_n), .set_i(emp_set), .clr_we(wr_emp),
    .keep_mask(wr_data), .q(emp_sts));
  usbpst_flag_bank #(.W(2)) u_err (
    .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_we(wr_err),
    .keep_mask(wr_data[1:0]), .q(err_flags));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_en  <= '0;
      nrdy_en <= '0;
      emp_en  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_RDYEN)  rdy_en  <= wr_data;
      if (wr_sel == SEL_NRDYEN) nrdy_en <= wr_data;
      if (wr_sel == SEL_EMPEN)  emp_en  <= wr_data;
    end
  end

  usbpst_irq_merge #(.NP(NP)) u_irq (
    .rdy_sts(rdy_sts), .nrdy_sts(nrdy_sts), .emp_sts(emp_sts),
    .rdy_en(rdy_en), .nrdy_en(nrdy_en), .emp_en(emp_en), .irq(irq)
  );
endmodule

// File: rtl/usbpst_chk.sv
module usbpst_chk #(
  parameter int NP = 4,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic [PW-1:0]   ev_pipe,
  input logic            ev_crc,
  input logic            ev_mps_over,
  input logic [2*NP-1:0] cfg_resp,
  input logic [NP-1:0]   cfg_iso,
  input logic [NP-1:0]   rdy_sts,
  input logic [NP-1:0]   nrdy_sts,
  input logic [NP-1:0]   emp_sts,
  input logic [1:0]      err_flags,
  input logic            irq,
  input logic [NP-1:0]   rdy_set,
  input logic [NP-1:0]   nrdy_set,
  input logic [NP-1:0]   emp_set,
  input logic [NP-1:0]   rdy_en,
  input logic [NP-1:0]   nrdy_en,
  input logic [NP-1:0]   emp_en
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rdy_sts == '0 && nrdy_sts == '0 && emp_sts == '0
                      && err_flags == '0 && !irq));

  p_crc_iso_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[0]) |-> $past(ev_valid && ev_crc && cfg_iso[ev_pipe]));

  p_stall_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_mps_over) |-> (rdy_set == '0));

  p_irq_rdy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdy_sts & rdy_en) != '0) |-> irq);

  p_irq_nrdy_emp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (((nrdy_sts & nrdy_en) | (emp_sts & emp_en)) != '0) |-> irq);

  for (genvar i = 0; i < NP; i++) begin : g_pp
    p_nrdy_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nrdy_sts[i]) |-> ($past(cfg_resp[2*i +: 2]) == 2'b01));
    p_set_wins_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_set[i] |=> rdy_sts[i]);
    p_set_wins_nrdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      nrdy_set[i] |=> nrdy_sts[i]);
    p_set_wins_emp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      emp_set[i] |=> emp_sts[i]);
  end
endmodule

bind pipe_ready_irq usbpst_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pipe(ev_pipe),
  .ev_crc(ev_crc), .ev_mps_over(ev_mps_over), .cfg_resp(cfg_resp),
  .cfg_iso(cfg_iso), .rdy_sts(rdy_sts), .nrdy_sts(nrdy_sts),
  .emp_sts(emp_sts), .err_flags(err_flags), .irq(irq),
  .rdy_set(rdy_set), .nrdy_set(nrdy_set), .emp_set(emp_set),
  .rdy_en(rdy_en), .nrdy_en(nrdy_en), .emp_en(emp_en)
);

// File: tb/pipe_ready_irq_tb.sv
module pipe_ready_irq_tb_top;
  localparam int NP = 4;
  localparam int CW = 6;
  localparam int PW = 2;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0, ev_data = 0, ev_ack = 0, ev_nak = 0, ev_short = 0;
  logic ev_crc = 0, ev_ovrn = 0, ev_mps_over = 0, ev_tx_empty = 0;
  logic [PW-1:0] ev_pipe = '0;
  logic [1:0] ev_token = '0;
  logic [NP-1:0] cpu_unread = '0, cfg_iso = '0, cfg_eot = '0;
  logic [2*NP-1:0] cfg_resp = '0;
  logic [CW*NP-1:0] cfg_trncnt = '0;
  logic wr_en = 0;
  logic [2:0] wr_sel = '0;
  logic [NP-1:0] wr_data = '0;
  logic [NP-1:0] rdy_sts, nrdy_sts, emp_sts;
  logic [1:0] err_flags;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  pipe_ready_irq #(.NP(NP), .CW(CW)) dut_i (.*);

  // behavioural reference model
  bit [NP-1:0] mr, mn, me, er, en_, ee;
  bit [1:0] merr;
  int mcnt [NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      mr = 0; mn = 0; me = 0; er = 0; en_ = 0; ee = 0; merr = 0;
      foreach (mcnt[k]) mcnt[k] = 0;
    end else begin
      int p;
      bit iso, buf_mode, hs, good_rx, good_tx, ends;
      int lim;
      p = int'(ev_pipe);
      if (wr_en) begin
        case (wr_sel)
          3'd0: mr &= wr_data;
          3'd1: mn &= wr_data;
          3'd2: me &= wr_data;
          3'd3: er = wr_data;
          3'd4: en_ = wr_data;
          3'd5: ee = wr_data;
          3'd6: merr &= wr_data[1:0];
          default: ;
        endcase
      end
      if (ev_valid) begin
        iso = cfg_iso[p];
        buf_mode = (cfg_resp[2*p +: 2] == 2'b01);
        hs = iso || ev_ack;
        if (buf_mode && ((ev_nak && !iso) || (iso && (ev_crc || ev_ovrn))))
          mn[p] = 1;
        if (iso && ev_crc)  merr[0] = 1;
        if (iso && ev_ovrn) merr[1] = 1;
        good_rx = ev_token == 2'b01 && ev_data && hs && !ev_nak && !ev_crc
                  && !ev_ovrn && !ev_mps_over;
        good_tx = ev_token == 2'b00 && ev_data && hs && !ev_nak;
        lim = int'(cfg_trncnt[CW*p +: CW]);
        ends = ev_short || (lim != 0 && mcnt[p] + 1 >= lim);
        if (good_tx) begin
          mr[p] = 1;
          if (ev_tx_empty) me[p] = 1;
        end
        if (good_rx) begin
          if (cfg_eot[p]) begin
            if (ends) begin mr[p] = 1; mcnt[p] = 0; end
            else mcnt[p] = mcnt[p] + 1;
          end else if (!cpu_unread[p]) mr[p] = 1;
        end
        if (ev_token == 2'b01 && ev_mps_over && !iso) me[p] = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(rdy_sts == mr, "R4/R5/R6/R8 ready", rdy_sts, mr);
    chk(nrdy_sts == mn, "R2/R3 not-ready", nrdy_sts, mn);
    chk(emp_sts == me, "R6/R7 empty", emp_sts, me);
    chk(err_flags == merr, "R3 error flags", err_flags, merr);
    chk(irq == (|{mr & er, mn & en_, me & ee}), "R11 irq", irq,
        |{mr & er, mn & en_, me & ee});
  end

  task automatic ev(input int p, input logic [1:0] tok, input bit dat,
                    input bit ack, input bit nak, input bit shrt = 0,
                    input bit crc = 0, input bit ovr = 0, input bit mps = 0,
                    input bit emp = 0);
    @(negedge clk);
    ev_valid = 1; ev_pipe = PW'(p); ev_token = tok; ev_data = dat;
    ev_ack = ack; ev_nak = nak; ev_short = shrt; ev_crc = crc;
    ev_ovrn = ovr; ev_mps_over = mps; ev_tx_empty = emp;
    @(negedge clk);
    ev_valid = 0; ev_data = 0; ev_ack = 0; ev_nak = 0; ev_short = 0;
    ev_crc = 0; ev_ovrn = 0; ev_mps_over = 0; ev_tx_empty = 0;
  endtask

  task automatic wr(input int sel, input logic [NP-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdy_sts == 0 && nrdy_sts == 0 && emp_sts == 0 && err_flags == 0 && !irq,
        "R1 reset", {rdy_sts, nrdy_sts, emp_sts}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(irq == 0, "R1 irq after reset", irq, 0);

    // R2: pipe0 buffer mode, pipe1 NAK mode
    cfg_resp = 8'b00_00_00_01;
    ev(0, 2'b00, 0, 0, 1);
    chk(nrdy_sts[0] == 1, "R2 IN nak", nrdy_sts, 1);
    ev(1, 2'b01, 0, 0, 1);
    chk(nrdy_sts[1] == 0, "R2 gated resp", nrdy_sts, 1);
    wr(1, 4'b1110);
    chk(nrdy_sts == 0, "R9 clear nrdy0", nrdy_sts, 0);
    ev(0, 2'b10, 0, 0, 1);
    chk(nrdy_sts[0] == 1, "R2 PING nak", nrdy_sts, 1);

    // R10 enables
    wr(3, 4'b1111); wr(4, 4'b0000); wr(5, 4'b1111);
    chk(irq == 0, "R11 nrdy disabled", irq, 0);
    wr(4, 4'b0001);
    chk(irq == 1, "R10 enable load", irq, 1);

    // R4 receive with end-of-transfer off
    cfg_unread_set: cpu_unread = 4'b1000;
    ev(2, 2'b01, 1, 1, 0);
    chk(rdy_sts[2] == 1, "R4 rx ready", rdy_sts, 4);
    ev(3, 2'b01, 1, 1, 0, 1);
    chk(rdy_sts[3] == 0, "R4 unread blocks", rdy_sts, 4);
    cpu_unread = 0;

    // R5 end-of-transfer, limit 3 on pipe1
    cfg_eot = 4'b0010;
    cfg_trncnt[CW*1 +: CW] = CW'(3);
    ev(1, 2'b01, 1, 1, 0);
    ev(1, 2'b01, 1, 1, 0);
    chk(rdy_sts[1] == 0, "R5 not yet", rdy_sts, 0);
    ev(1, 2'b01, 1, 1, 0);
    chk(rdy_sts[1] == 1, "R5 count end", rdy_sts, 2);
    wr(0, 4'b1101);
    ev(1, 2'b01, 1, 1, 0, 1);
    chk(rdy_sts[1] == 1, "R5 short ends", rdy_sts, 2);

    // R6 transmit
    wr(0, 4'b0000);
    ev(0, 2'b00, 1, 0, 0, 0, 0, 0, 0, 1);
    chk(rdy_sts[0] == 0 && emp_sts[0] == 0, "R6 no ack", rdy_sts, 0);
    ev(0, 2'b00, 1, 1, 0, 0, 0, 0, 0, 1);
    chk(rdy_sts[0] == 1 && emp_sts[0] == 1, "R6 acked empty", emp_sts, 1);

    // R7 oversize stall
    ev(2, 2'b01, 1, 1, 0, 0, 0, 0, 1);
    chk(emp_sts[2] == 1 && rdy_sts[2] == 0, "R7 stall", rdy_sts, 0);

    // R3/R8 isochronous pipe3, buffer mode
    ev(1, 2'b01, 1, 1, 0, 0, 1);
    chk(err_flags == 0, "R3 non-iso crc", err_flags, 0);
    cfg_iso = 4'b1000;
    cfg_resp[7:6] = 2'b01;
    ev(3, 2'b01, 1, 0, 0, 0, 1);
    chk(err_flags[0] == 1 && nrdy_sts[3] == 1, "R3 iso crc", err_flags, 1);
    ev(3, 2'b01, 0, 0, 0, 0, 0, 1);
    chk(err_flags == 2'b11, "R3 iso overrun", err_flags, 3);
    wr(6, 4'b0001);
    chk(err_flags == 2'b01, "R9 clear ovrn", err_flags, 1);
    ev(3, 2'b01, 1, 0, 0);
    chk(rdy_sts[3] == 1, "R8 iso no ack", rdy_sts, 8);

    // R9 set wins over simultaneous clear
    wr(0, 4'b0000);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'd0; wr_data = 4'b0000;
    ev_valid = 1; ev_pipe = 2'd0; ev_token = 2'b00; ev_data = 1; ev_ack = 1;
    @(negedge clk);
    wr_en = 0; ev_valid = 0; ev_data = 0; ev_ack = 0;
    chk(rdy_sts == 4'b0001, "R9 set wins", rdy_sts, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule